// File: doc/BRIEF.md
# Multiply Unit Result Stage

This block is the result stage of a 64-bit integer multiply unit. Each cycle it takes two 64-bit operands, an operation kind, a 32-bit-mode flag, a signed flag, an opaque context tag with its mux identifier, and the incoming summary-overflow bit. One clock edge later it presents the formatted 64-bit result and a result-valid flag. For low-half operations it also presents a 2-bit overflow field with a write-enable. The context, mux identifier and summary-overflow bit are carried alongside the result.

Signed products are formed from operand magnitudes. When exactly one operand is negative, the whole double-width product is negated. The operation kind picks one of three views of that product: the upper word of a 32x32 product copied into both halves of the output, the upper 64 bits of a 64x64 product, or the low 64 bits. A low-half result overflows when the bits it drops, together with its own sign bit, are not all copies of one value.

Top module: `mul_result_stage`

## Requirements
- R1: With `op_kind` = 0 (high-32), only bits 31..0 of each operand are used. The output is bits 63..32 of their 64-bit product, and that 32-bit value appears in both output bits 63..32 and bits 31..0.
- R2: With `op_kind` = 1 (high-64), the output is bits 127..64 of the 128-bit product of the full 64-bit operands.
- R3: With `op_kind` = 2 and `mode32` = 1, only bits 31..0 of each operand are used, and the output is the whole 64-bit product.
- R4: With `op_kind` = 2 and `mode32` = 0, the output is bits 63..0 of the 128-bit product of the full operands.
- R5: With `is_signed` = 1, operands are two's complement. A 32-bit operand is sign-extended from its bit 31. The product carries the sign implied by the two operand signs, and the most negative operand value is handled correctly. With `is_signed` = 0, operands are unsigned and a 32-bit operand is zero-extended.
- R6: With `op_kind` = 2 and `mode32` = 1, the overflow field `ov_bits` is 2'b11 when product bits 63..31 contain both ones and zeros, and 2'b00 otherwise.
- R7: With `op_kind` = 2 and `mode32` = 0, `ov_bits` is 2'b11 when product bits 127..63 contain both ones and zeros, and 2'b00 otherwise.
- R8: `ov_we` is 1 exactly when `op_kind` = 2. When `ov_we` is 0, `ov_bits` is 2'b00.
- R9: `result_vld` is 1 for `op_kind` 0, 1 and 2. For `op_kind` = 3 it is 0 and `result` is zero.
- R10: `ctx_out`, `muxid_out` and `so_out` equal the `ctx_in`, `muxid_in` and `so_in` of the same operation.
- R11: All outputs are registered and show the operation presented at the previous rising clock edge. While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_kind | input | 2 | 0 high-32, 1 high-64, 2 low-64, 3 invalid |
| mode32 | input | 1 | 32-bit mode for the low-64 kind |
| is_signed | input | 1 | Treat operands as two's complement |
| ctx_in | input | CTX_W (16) | Operation context tag |
| muxid_in | input | MUXID_W (4) | Mux identifier |
| so_in | input | 1 | Incoming summary-overflow bit |
| result | output | 64 | Formatted product |
| result_vld | output | 1 | Result is valid |
| ov_bits | output | 2 | Overflow pair, both bits equal |
| ov_we | output | 1 | Overflow field write-enable |
| ctx_out | output | CTX_W (16) | Context pass-through |
| muxid_out | output | MUXID_W (4) | Mux identifier pass-through |
| so_out | output | 1 | Summary-overflow pass-through |

## Verification
Every result of this block is due exactly one rising edge after its operands are driven: the formatted product, the valid flag, the overflow pair with its enable, and the pass-through fields all land in the same output register. The driver applies inputs at the falling edge and queues the expected record. The monitor wakes shortly after the next rising edge and removes exactly one queued record for each operation, so any added or missing pipeline stage shows up as mismatches. The reset values are sampled at a falling edge while reset is held.

// File: rtl/mul_stage_pkg.sv
package mul_stage_pkg;

    typedef enum logic [1:0] {
        MK_HI32 = 2'd0,
        MK_HI64 = 2'd1,
        MK_LO64 = 2'd2,
        MK_NONE = 2'd3
    } mul_kind_e;

    // True when a window of product bits is not a run of identical bits.
    function automatic logic mixed_run(input logic any_set, input logic all_set);
        return any_set & ~all_set;
    endfunction

    function automatic logic kind_is_valid(input mul_kind_e k);
        return k != MK_NONE;
    endfunction

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
    import mul_stage_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    input  mul_kind_e       kind,
    input  logic            mode32,
    input  logic            is_signed,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output logic            negate,
    output logic            narrow
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] raw   [2];
    logic [XLEN-1:0] ext   [2];
    logic [XLEN-1:0] mag   [2];
    logic            neg_s [2];

    assign narrow = (kind == MK_HI32) || ((kind == MK_LO64) && mode32);
    assign raw[0] = a_in;
    assign raw[1] = b_in;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        always_comb begin
            if (narrow) begin
                ext[g] = is_signed ? {{HALF{raw[g][HALF-1]}}, raw[g][HALF-1:0]}
                                   : {{HALF{1'b0}}, raw[g][HALF-1:0]};
            end else begin
                ext[g] = raw[g];
            end
            neg_s[g] = is_signed & ext[g][XLEN-1];
            mag[g]   = neg_s[g] ? (~ext[g] + {{(XLEN-1){1'b0}}, 1'b1}) : ext[g];
        end
    end

    assign mag_a  = mag[0];
    assign mag_b  = mag[1];
    assign negate = neg_s[0] ^ neg_s[1];

endmodule

// File: rtl/mul_magnitude_core.sv
module mul_magnitude_core #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   mag_a,
    input  logic [XLEN-1:0]   mag_b,
    input  logic              negate,
    output logic [2*XLEN-1:0] prod
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0] wide_a;
    logic [PW-1:0] wide_b;
    logic [PW-1:0] unsigned_prod;

    assign wide_a        = {{XLEN{1'b0}}, mag_a};
    assign wide_b        = {{XLEN{1'b0}}, mag_b};
    assign unsigned_prod = wide_a * wide_b;
    assign prod          = negate ? (~unsigned_prod + {{(PW-1){1'b0}}, 1'b1}) : unsigned_prod;

endmodule

// File: rtl/mul_result_form.sv
module mul_result_form
    import mul_stage_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] prod,
    input  mul_kind_e         kind,
    input  logic              narrow,
    output logic [XLEN-1:0]   result,
    output logic              vld,
    output logic [1:0]        ov,
    output logic              ov_we
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-HALF:0] win_narrow;   // product bits XLEN-1 .. HALF-1
    logic [XLEN:0]      win_wide;     // product bits 2*XLEN-1 .. XLEN-1
    logic               ov_narrow;
    logic               ov_wide;
    logic               ov_sel;

    assign win_narrow = prod[XLEN-1:HALF-1];
    assign win_wide   = prod[2*XLEN-1:XLEN-1];
    assign ov_narrow  = mixed_run(|win_narrow, &win_narrow);
    assign ov_wide    = mixed_run(|win_wide, &win_wide);
    assign ov_sel     = narrow ? ov_narrow : ov_wide;

    always_comb begin
        result = '0;
        ov     = 2'b00;
        ov_we  = 1'b0;
        vld    = kind_is_valid(kind);
        unique case (kind)
            MK_HI32: result = {prod[XLEN-1:HALF], prod[XLEN-1:HALF]};
            MK_HI64: result = prod[2*XLEN-1:XLEN];
            MK_LO64: begin
                result = prod[XLEN-1:0];
                ov     = {2{ov_sel}};
                ov_we  = 1'b1;
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/mul_result_stage.sv
module mul_result_stage
    import mul_stage_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CTX_W   = 16,
    parameter int MUXID_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [XLEN-1:0]    op_a,
    input  logic [XLEN-1:0]    op_b,
    input  logic [1:0]         op_kind,
    input  logic               mode32,
    input  logic               is_signed,
    input  logic [CTX_W-1:0]   ctx_in,
    input  logic [MUXID_W-1:0] muxid_in,
    input  logic               so_in,
    output logic [XLEN-1:0]    result,
    output logic               result_vld,
    output logic [1:0]         ov_bits,
    output logic               ov_we,
    output logic [CTX_W-1:0]   ctx_out,
    output logic [MUXID_W-1:0] muxid_out,
    output logic               so_out
);
    localparam int HALF = XLEN / 2;

    mul_kind_e         kind;
    logic [XLEN-1:0]   mag_a, mag_b;
    logic              negate, narrow;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   res_c;
    logic              vld_c, we_c;
    logic [1:0]        ov_c;

    assign kind = mul_kind_e'(op_kind);

    mul_operand_prep #(.XLEN(XLEN)) u_prep (
        .a_in(op_a), .b_in(op_b), .kind(kind), .mode32(mode32),
        .is_signed(is_signed), .mag_a(mag_a), .mag_b(mag_b),
        .negate(negate), .narrow(narrow)
    );

    mul_magnitude_core #(.XLEN(XLEN)) u_core (
        .mag_a(mag_a), .mag_b(mag_b), .negate(negate), .prod(prod)
    );

    mul_result_form #(.XLEN(XLEN)) u_form (
        .prod(prod), .kind(kind), .narrow(narrow), .result(res_c),
        .vld(vld_c), .ov(ov_c), .ov_we(we_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            result_vld <= 1'b0;
            ov_bits    <= 2'b00;
            ov_we      <= 1'b0;
            ctx_out    <= '0;
            muxid_out  <= '0;
            so_out     <= 1'b0;
        end else begin
            result     <= res_c;
            result_vld <= vld_c;
            ov_bits    <= ov_c;
            ov_we      <= we_c;
            ctx_out    <= ctx_in;
            muxid_out  <= muxid_in;
            so_out     <= so_in;
        end
    end

    // One cycle of history is valid once reset was low at the previous edge.
    logic hist_ok;
    always_ff @(posedge clk) begin
        if (rst) hist_ok <= 1'b0;
        else     hist_ok <= 1'b1;
    end

    assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (ctx_out == $past(ctx_in) && muxid_out == $past(muxid_in)
                     && so_out == $past(so_in)));

    assert_valid_kind_R9: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (result_vld == ($past(op_kind) != 2'd3)));

    assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(op_kind) == 2'd3) |-> (result == '0));

    assert_ov_enable_R8: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (ov_we == ($past(op_kind) == 2'd2)));

    assert_ov_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !ov_we |-> (ov_bits == 2'b00));

    assert_ov_pair_R6: assert property (@(posedge clk) disable iff (rst)
        ov_we |-> (ov_bits == 2'b00 || ov_bits == 2'b11));

    assert_hi32_mirror_R1: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(op_kind) == 2'd0) |-> (result[XLEN-1:HALF] == result[HALF-1:0]));

    assert_reset_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> (result == '0 && !result_vld && !ov_we && ov_bits == 2'b00));

endmodule

// File: tb/test_mul_result_stage.sv
module test_mul_result_stage;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int CTX_W = 16;
    localparam int MUXID_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [XLEN-1:0]    op_a = '0, op_b = '0;
    logic [1:0]         op_kind = 2'd3;
    logic               mode32 = 1'b0, is_signed = 1'b0;
    logic [CTX_W-1:0]   ctx_in = '0;
    logic [MUXID_W-1:0] muxid_in = '0;
    logic               so_in = 1'b0;
    logic [XLEN-1:0]    result;
    logic               result_vld;
    logic [1:0]         ov_bits;
    logic               ov_we;
    logic [CTX_W-1:0]   ctx_out;
    logic [MUXID_W-1:0] muxid_out;
    logic               so_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mul_result_stage i_mul_result_stage (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_kind(op_kind),
        .mode32(mode32), .is_signed(is_signed), .ctx_in(ctx_in),
        .muxid_in(muxid_in), .so_in(so_in), .result(result),
        .result_vld(result_vld), .ov_bits(ov_bits), .ov_we(ov_we),
        .ctx_out(ctx_out), .muxid_out(muxid_out), .so_out(so_out)
    );

    typedef struct {
        logic [63:0]        res;
        logic               vld;
        logic [1:0]         ov;
        logic               we;
        logic [CTX_W-1:0]   ctx;
        logic [MUXID_W-1:0] mid;
        logic               so;
        string              tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: two's-complement arithmetic at 128 bits.
    function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] k, input logic m32, input logic sg);
        exp_t e;
        logic [127:0] sa, sb, p;
        logic         nar;
        logic [32:0]  wn;
        logic [64:0]  ww;
        nar = (k == 2'd0) || (k == 2'd2 && m32);
        if (nar) begin
            sa = sg ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
            sb = sg ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
        end else begin
            sa = sg ? {{64{a[63]}}, a} : {64'b0, a};
            sb = sg ? {{64{b[63]}}, b} : {64'b0, b};
        end
        p = sa * sb;
        wn = p[63:31];
        ww = p[127:63];
        e.vld = (k != 2'd3);
        e.we  = (k == 2'd2);
        e.ov  = 2'b00;
        case (k)
            2'd0: e.res = {p[63:32], p[63:32]};
            2'd1: e.res = p[127:64];
            2'd2: begin
                e.res = p[63:0];
                if (nar) e.ov = (wn != '0 && wn != '1) ? 2'b11 : 2'b00;
                else     e.ov = (ww != '0 && ww != '1) ? 2'b11 : 2'b00;
            end
            default: e.res = '0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] k,
                         input logic m32, input logic sg, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; op_kind = k; mode32 = m32; is_signed = sg;
        ctx_in = 16'($urandom); muxid_in = 4'($urandom); so_in = 1'($urandom);
        e = model(a, b, k, m32, sg);
        e.ctx = ctx_in; e.mid = muxid_in; e.so = so_in; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one record per operation, due one rising edge after driving.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " result R11"}, result, e.res);
                check("R9 result_vld", {63'b0, result_vld}, {63'b0, e.vld});
                check("R8 ov_we", {63'b0, ov_we}, {63'b0, e.we});
                check({"R6/R7 ov_bits ", e.tag}, {62'b0, ov_bits}, {62'b0, e.ov});
                check("R10 passthrough", {43'b0, so_out, muxid_out, ctx_out},
                      {43'b0, e.so, e.mid, e.ctx});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        op_a = '1; op_b = '1; op_kind = 2'd2; ctx_in = '1; so_in = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset clears all outputs
        check("R11 reset result", result, 64'h0);
        check("R11 reset flags", {60'b0, result_vld, ov_we, ov_bits}, 64'h0);
        check("R11 reset passthrough", {43'b0, so_out, muxid_out, ctx_out}, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1 high-32
        drive(64'hFFFF_0000_8000_0000, 64'h1234_0000_0000_0004, 2'd0, 1'b0, 1'b0, "R1 hi32 unsigned");
        drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 2'd0, 1'b1, 1'b1, "R1 R5 hi32 signed");
        drive(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 2'd0, 1'b0, 1'b1, "R1 R5 hi32 minneg");
        // R2 high-64
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, 1'b0, "R2 hi64 unsigned");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 2'd1, 1'b0, 1'b1, "R2 R5 hi64 signed");
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd1, 1'b0, 1'b1, "R2 R5 hi64 minneg");
        // R3 / R6 low-64 32-bit mode
        drive(64'hDEAD_0000_7FFF_FFFF, 64'h0000_0000_0000_0002, 2'd2, 1'b1, 1'b1, "R3 R6 lo32 overflow");
        drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 2'd2, 1'b1, 1'b1, "R3 R6 lo32 -1*-1");
        drive(64'h0000_0000_0001_0000, 64'h0000_0000_FFFF_8000, 2'd2, 1'b1, 1'b1, "R3 R6 lo32 -2^31 fits");
        drive(64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 2'd2, 1'b1, 1'b1, "R3 R6 lo32 +2^31 over");
        drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0003, 2'd2, 1'b1, 1'b0, "R3 R5 lo32 unsigned");
        // R4 / R7 low-64 64-bit mode
        drive(64'h4000_0000_0000_0000, 64'h0000_0000_0000_0002, 2'd2, 1'b0, 1'b1, "R4 R7 lo64 overflow");
        drive(64'hC000_0000_0000_0000, 64'h0000_0000_0000_0002, 2'd2, 1'b0, 1'b1, "R4 R7 lo64 min fits");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 2'd2, 1'b0, 1'b1, "R4 R7 lo64 small neg");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 2'd2, 1'b0, 1'b0, "R4 R7 lo64 unsigned");
        // R9 invalid kind, R8 no overflow write outside low kind
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1, "R9 invalid");
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 1'b1, "R8 hi64 no ovwe");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                  1'($urandom), 1'($urandom), "R1-4 random");
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule